// File: doc/BRIEF.md
# Partitioned Masked Associative Search Array

This block is a content-addressable store of `DEPTH` entries, each 64 bits wide. Any entry can be written or read at its address. A single compare checks a 64-bit key against every entry at once. Each stored word carries a 2-bit type tag that marks it as Valid, Skip, Empty or RAM. A compare considers only the entries whose tag equals the requested type. An automatic lookup is a compare with the type set to Valid, and maintenance passes can target Skip, Empty or RAM entries.

The compared width is set in two ways. A global partition code chooses how many 16-bit segments, counted from the most significant end, belong to the compared CAM part. The remaining low segments form an associated RAM part that never affects a match. A bitwise mask then turns single key bits into don't-cares.

The per-entry hit lines feed a priority encoder. The compare result is registered and shows the lowest matching address, a match flag and a multiple-match flag. A second encoder reports the lowest Empty address at all times, which a writer uses to find space for a new entry.

Top module: `cam_search_array`

## Requirements
- R1: After reset every entry has type Empty with all-zero data. `match_flag`, `multi_flag`, `match_addr`, `rd_data` and `rd_status` are 0, `free_flag` is 1 and `free_addr` is 0.
- R2: A write with `wr_en` stores `wr_data` and the type `wr_type` at `wr_addr`. The type encodings are 2'b00 Valid, 2'b01 Skip, 2'b10 Empty and 2'b11 RAM. A read with `rd_en` presents that entry's data on `rd_data` and its type on `rd_status` one clock later. Both outputs hold while `rd_en` is low.
- R3: Partition code n (0 to 3) compares the top (n+1)×16 bits, bits 63 down to 64−16(n+1). Bits below that boundary never affect a match.
- R4: A `cmp_mask` bit of 1 makes that key bit a don't-care for every entry.
- R5: A compare includes only entries whose type equals `cmp_type`.
- R6: On a hit, `match_addr` is the lowest matching address and `match_flag` is 1. With no hit, `match_flag` is 0 and `match_addr` is 0.
- R7: `multi_flag` is 1 exactly when two or more entries hit. It is never 1 while `match_flag` is 0.
- R8: Compare results appear on the clock edge that samples `cmp_en` and hold until the next compare or clear. A compare issued in the same cycle as a write sees the contents from before that write.
- R9: `match_clr` zeroes `match_flag`, `multi_flag` and `match_addr` on the next edge. It wins over a simultaneous `cmp_en`.
- R10: `free_addr` is the lowest address of type Empty and `free_flag` is 1 while such an entry exists. With no Empty entry, both are 0. They reflect a write from the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | ENTRY_W | Write data |
| wr_type | input | 2 | Type tag written with the data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | ENTRY_W | Registered read data |
| rd_status | output | 2 | Registered type tag of the entry read |
| cmp_en | input | 1 | Compare strobe |
| cmp_key | input | ENTRY_W | Comparand |
| cmp_mask | input | ENTRY_W | Don't-care mask, 1 = ignore bit |
| cmp_segs | input | SEL_W | Partition code: CAM segments minus one |
| cmp_type | input | 2 | Entry type that the compare targets |
| match_clr | input | 1 | Clears the match result |
| match_flag | output | 1 | At least one entry hit |
| multi_flag | output | 1 | Two or more entries hit |
| match_addr | output | AW | Lowest hitting address |
| free_flag | output | 1 | An Empty entry exists |
| free_addr | output | AW | Lowest Empty address |

## Verification
The same stored words are searched repeatedly while changing one compare input at a time:
- **Full width against a narrower partition.** A key that differs from one entry only in the lowest segment separates the two. With the full width only the exact entry hits. With three segments both entries hit, which exposes a wrong boundary or a missing multiple-match flag.
- **Mask alone.** Masking exactly the differing segment shows that the mask alone has the same effect as the narrower partition.
- **Identical data under different tags.** This shows that the type select, and not the data, decides the hit.
- **One-segment search.** A key whose low bits are all garbage tests that RAM bits are ignored.
- **Miss patterns.** These check the zero address on a miss.

Directed sequences cover the following:
- Filling the array to prove the empty-slot encoder runs out correctly.
- Clears that collide with compares.
- Result holding while the key changes without a strobe.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    VT_VALID = 2'b00,
    VT_SKIP  = 2'b01,
    VT_EMPTY = 2'b10,
    VT_RAM   = 2'b11
  } vtype_e;

endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/cam_hit_lines.sv
module cam_hit_lines #(
  parameter int DEPTH   = 256,
  parameter int ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] ent_data [DEPTH],
  input  logic [1:0]         ent_type [DEPTH],
  input  logic [ENTRY_W-1:0] key,
  input  logic [ENTRY_W-1:0] care,
  input  logic [1:0]         want_type,
  output logic [DEPTH-1:0]   hit
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_line
    logic [ENTRY_W-1:0] diff;
    assign diff   = (ent_data[e] ^ key) & care;
    assign hit[e] = (ent_type[e] == want_type) && (diff == '0);
  end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic             many,
  output logic [AW-1:0]    idx
);

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

  assign any  = |req;
  assign many = |(req & (req - 1'b1));

endmodule

// File: rtl/cam_search_array.sv
module cam_search_array #(
  parameter int DEPTH   = 256,
  parameter int ENTRY_W = 64,
  parameter int SEG_W   = 16,
  localparam int NSEG   = ENTRY_W / SEG_W,
  localparam int SEL_W  = $clog2(NSEG),
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [1:0]         wr_type,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [1:0]         rd_status,
  input  logic               cmp_en,
  input  logic [ENTRY_W-1:0] cmp_key,
  input  logic [ENTRY_W-1:0] cmp_mask,
  input  logic [SEL_W-1:0]   cmp_segs,
  input  logic [1:0]         cmp_type,
  input  logic               match_clr,
  output logic               match_flag,
  output logic               multi_flag,
  output logic [AW-1:0]      match_addr,
  output logic               free_flag,
  output logic [AW-1:0]      free_addr
);

  import cam_pkg::*;

  logic srst_n;

  cam_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // Entry storage: one enabled register pair per entry
  logic [ENTRY_W-1:0] ent_data [DEPTH];
  logic [1:0]         ent_type [DEPTH];
  logic [DEPTH-1:0]   is_empty;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic we;
    assign we = wr_en && (wr_addr == AW'(e));

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        ent_data[e] <= '0;
        ent_type[e] <= VT_EMPTY;
      end else if (we) begin
        ent_data[e] <= wr_data;
        ent_type[e] <= wr_type;
      end
    end

    assign is_empty[e] = (ent_type[e] == VT_EMPTY);
  end

  // Compare-width mask from the partition code: top segments are CAM
  logic [ENTRY_W-1:0] care;

  always_comb begin
    care = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (s >= NSEG - 1 - int'(cmp_segs)) begin
        care[s*SEG_W +: SEG_W] = ~cmp_mask[s*SEG_W +: SEG_W];
      end
    end
  end

  logic [DEPTH-1:0] hit;

  cam_hit_lines #(
    .DEPTH   (DEPTH),
    .ENTRY_W (ENTRY_W)
  ) u_hits (
    .ent_data  (ent_data),
    .ent_type  (ent_type),
    .key       (cmp_key),
    .care      (care),
    .want_type (cmp_type),
    .hit       (hit)
  );

  logic          hit_any, hit_many;
  logic [AW-1:0] hit_idx;

  cam_prio_enc #(.DEPTH(DEPTH)) u_match_enc (
    .req  (hit),
    .any  (hit_any),
    .many (hit_many),
    .idx  (hit_idx)
  );

  logic          free_many;

  cam_prio_enc #(.DEPTH(DEPTH)) u_free_enc (
    .req  (is_empty),
    .any  (free_flag),
    .many (free_many),
    .idx  (free_addr)
  );

  // Match result registers
  logic          mflag_d, mflag_q, multi_d, multi_q;
  logic [AW-1:0] maddr_d, maddr_q;

  always_comb begin
    mflag_d = mflag_q;
    multi_d = multi_q;
    maddr_d = maddr_q;
    if (match_clr) begin
      mflag_d = 1'b0;
      multi_d = 1'b0;
      maddr_d = '0;
    end else if (cmp_en) begin
      mflag_d = hit_any;
      multi_d = hit_many;
      maddr_d = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mflag_q <= 1'b0;
      multi_q <= 1'b0;
      maddr_q <= '0;
    end else begin
      mflag_q <= mflag_d;
      multi_q <= multi_d;
      maddr_q <= maddr_d;
    end
  end

  // Read port
  logic [ENTRY_W-1:0] rdata_d, rdata_q;
  logic [1:0]         rstat_d, rstat_q;

  always_comb begin
    rdata_d = rdata_q;
    rstat_d = rstat_q;
    if (rd_en) begin
      rdata_d = ent_data[rd_addr];
      rstat_d = ent_type[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      rstat_q <= 2'b00;
    end else begin
      rdata_q <= rdata_d;
      rstat_q <= rstat_d;
    end
  end

  assign match_flag = mflag_q;
  assign multi_flag = multi_q;
  assign match_addr = maddr_q;
  assign rd_data    = rdata_q;
  assign rd_status  = rstat_q;

endmodule

// File: rtl/cam_search_checks.sv
module cam_search_checks #(
  parameter int AW      = 8,
  parameter int ENTRY_W = 64
) (
  input logic               clk,
  input logic               srst_n,
  input logic               cmp_en,
  input logic               match_clr,
  input logic               rd_en,
  input logic [ENTRY_W-1:0] rd_data,
  input logic [1:0]         rd_status,
  input logic               match_flag,
  input logic               multi_flag,
  input logic [AW-1:0]      match_addr,
  input logic               free_flag,
  input logic [AW-1:0]      free_addr
);

  // R9
  clr_zeroes_chk: assert property (@(posedge clk) disable iff (!srst_n)
    match_clr |=> (!match_flag && !multi_flag && match_addr == '0));

  // R7
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
    multi_flag |-> match_flag);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!cmp_en && !match_clr) |=> $stable({match_flag, multi_flag, match_addr}));

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> ($stable(rd_data) && $stable(rd_status)));

  // R6
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !match_flag |-> (match_addr == '0));

  // R10
  full_addr_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !free_flag |-> (free_addr == '0));

endmodule

bind cam_search_array cam_search_checks #(.AW(AW), .ENTRY_W(ENTRY_W)) u_checks (
  .clk        (clk),
  .srst_n     (srst_n),
  .cmp_en     (cmp_en),
  .match_clr  (match_clr),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_status  (rd_status),
  .match_flag (match_flag),
  .multi_flag (multi_flag),
  .match_addr (match_addr),
  .free_flag  (free_flag),
  .free_addr  (free_addr)
);

// File: tb/tb_cam_search_array.sv
module tb_cam_search_array;

  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk, rst_n;
  logic        wr_en, rd_en, cmp_en, match_clr;
  logic [7:0]  wr_addr, rd_addr;
  logic [63:0] wr_data, cmp_key, cmp_mask, rd_data;
  logic [1:0]  wr_type, cmp_type, cmp_segs, rd_status;
  logic        match_flag, multi_flag, free_flag;
  logic [7:0]  match_addr, free_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  cam_search_array #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_type(wr_type),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_status(rd_status),
    .cmp_en(cmp_en), .cmp_key(cmp_key), .cmp_mask(cmp_mask), .cmp_segs(cmp_segs),
    .cmp_type(cmp_type), .match_clr(match_clr),
    .match_flag(match_flag), .multi_flag(multi_flag), .match_addr(match_addr),
    .free_flag(free_flag), .free_addr(free_addr)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [63:0] key;
    logic [63:0] mask;
    logic [1:0]  segs;
    logic [1:0]  vt;
    logic        flag;
    logic        multi;
    logic [7:0]  addr;
  } vec_t;

  // Stored: 3 A..DDDD Valid, 5 A..1111 Valid, 7 A..DDDD Skip, 9 1234.. RAM
  localparam vec_t VECS [9] = '{
    '{64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 2'd3, 2'b00, 1'b1, 1'b0, 8'd3},
    '{64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 2'd2, 2'b00, 1'b1, 1'b1, 8'd3},
    '{64'hAAAA_BBBB_CCCC_2222, 64'h0000_0000_0000_FFFF, 2'd3, 2'b00, 1'b1, 1'b1, 8'd3},
    '{64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 2'd3, 2'b01, 1'b1, 1'b0, 8'd7},
    '{64'h1234_FFFF_FFFF_FFFF, 64'h0, 2'd0, 2'b11, 1'b1, 1'b0, 8'd9},
    '{64'h1234_FFFF_FFFF_FFFF, 64'h0, 2'd0, 2'b00, 1'b0, 1'b0, 8'd0},
    '{64'h0, 64'h0, 2'd3, 2'b10, 1'b1, 1'b1, 8'd0},
    '{64'hAAAA_BBBB_CCCC_DDDE, 64'h0, 2'd3, 2'b00, 1'b0, 1'b0, 8'd0},
    '{64'hFFFF_BBBB_CCCC_DDDD, 64'hFFFF_0000_0000_0000, 2'd3, 2'b00, 1'b1, 1'b0, 8'd3}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [63:0] d, logic [1:0] t);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_type = t;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_rd(logic [7:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_cmp(logic [63:0] k, logic [63:0] m, logic [1:0] s, logic [1:0] t);
    @(negedge clk);
    cmp_en = 1; cmp_key = k; cmp_mask = m; cmp_segs = s; cmp_type = t;
    @(negedge clk);
    cmp_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; cmp_en = 0; match_clr = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; wr_type = 0;
    cmp_key = 0; cmp_mask = 0; cmp_segs = 0; cmp_type = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 match_flag", 64'(match_flag), 64'h0);
    chk("R1 multi_flag", 64'(multi_flag), 64'h0);
    chk("R1 match_addr", 64'(match_addr), 64'h0);
    chk("R1 free_flag", 64'(free_flag), 64'h1);
    chk("R1 free_addr", 64'(free_addr), 64'h0);
    chk("R1 rd_data", rd_data, 64'h0);
    do_rd(8'd100);
    chk("R1 entry type empty", 64'(rd_status), 64'h2);

    do_wr(8'd3, 64'hAAAA_BBBB_CCCC_DDDD, 2'b00);
    do_wr(8'd5, 64'hAAAA_BBBB_CCCC_1111, 2'b00);
    do_wr(8'd7, 64'hAAAA_BBBB_CCCC_DDDD, 2'b01);
    do_wr(8'd9, 64'h1234_5678_9ABC_DEF0, 2'b11);

    // R2 read back data and type, then hold
    do_rd(8'd7);
    chk("R2 rd_data", rd_data, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R2 rd_status", 64'(rd_status), 64'h1);
    rd_addr = 8'd9;
    @(negedge clk);
    chk("R2 hold without rd_en", rd_data, 64'hAAAA_BBBB_CCCC_DDDD);
    do_rd(8'd9);
    chk("R2 rd_status ram", 64'(rd_status), 64'h3);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      do_cmp(VECS[i].key, VECS[i].mask, VECS[i].segs, VECS[i].vt);
      chk($sformatf("R3/R4/R5/R6 flag vec%0d", i), 64'(match_flag), 64'(VECS[i].flag));
      chk($sformatf("R7 multi vec%0d", i), 64'(multi_flag), 64'(VECS[i].multi));
      chk($sformatf("R6 addr vec%0d", i), 64'(match_addr), 64'(VECS[i].addr));
    end

    // R8 result holds while key changes without strobe
    do_cmp(64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 2'd3, 2'b01);
    cmp_key = 64'h0; cmp_type = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8 hold flag", 64'(match_flag), 64'h1);
    chk("R8 hold addr", 64'(match_addr), 64'd7);

    // R9 clear, and clear beats compare
    @(negedge clk); match_clr = 1;
    @(negedge clk); match_clr = 0;
    chk("R9 clr flag", 64'(match_flag), 64'h0);
    chk("R9 clr addr", 64'(match_addr), 64'h0);
    @(negedge clk);
    match_clr = 1; cmp_en = 1; cmp_key = 64'hAAAA_BBBB_CCCC_DDDD;
    cmp_mask = 0; cmp_segs = 2'd3; cmp_type = 2'b00;
    @(negedge clk); match_clr = 0; cmp_en = 0;
    chk("R9 clr wins over cmp", 64'(match_flag), 64'h0);

    // R8 compare in same cycle as write sees old contents
    @(negedge clk);
    wr_en = 1; wr_addr = 8'd2; wr_data = 64'hAAAA_BBBB_CCCC_DDDD; wr_type = 2'b00;
    cmp_en = 1;
    @(negedge clk); wr_en = 0; cmp_en = 0;
    chk("R8 old contents addr", 64'(match_addr), 64'd3);
    do_cmp(64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 2'd3, 2'b00);
    chk("R8 new contents addr", 64'(match_addr), 64'd2);

    // R10 free pointer
    chk("R10 free lowest", 64'(free_addr), 64'd0);
    do_wr(8'd0, 64'h0, 2'b00);
    chk("R10 free after write", 64'(free_addr), 64'd1);
    for (int a = 0; a < DEPTH; a++) do_wr(8'(a), 64'(a), 2'b00);
    chk("R10 full flag", 64'(free_flag), 64'h0);
    chk("R10 full addr", 64'(free_addr), 64'h0);
    do_cmp(64'd77, 64'h0, 2'd3, 2'b00);
    chk("R6 filled lookup", 64'(match_addr), 64'd77);
    do_wr(8'd200, 64'h0, 2'b10);
    chk("R10 reopened flag", 64'(free_flag), 64'h1);
    chk("R10 reopened addr", 64'(free_addr), 64'd200);

    finish_run();
  end

endmodule